// File: doc/BRIEF.md
# Subchannel bit-field multiplexer

The block shares one 8-bit time-slot channel among several serial bit streams. The channel byte recurs once per frame, and a single-cycle strobe marks each frame. Each lane owns a contiguous field of the channel byte. The field is set by a start position and a bit count of 1 to 8. Per frame, the lane moves exactly that many bits between its byte FIFO and the channel.

In the transmit direction, each enabled lane draws bits from its FIFO bytes without regard to byte boundaries. A new FIFO byte is fetched part-way through a field when the current one runs out. All lanes' fields are merged into one registered outgoing byte, and positions no lane covers come from an idle mask byte. In the receive direction, each lane cuts the same field out of the incoming byte, packs the bits into bytes, and pushes every completed byte to its FIFO.

A transmit FIFO that cannot supply a needed byte causes an all-ones field and an underrun flag. A receive FIFO without space causes a dropped byte and an overflow flag. A registered checker flags configurations whose fields overlap or extend past bit 7.

Top module: `subch_mux`

## Requirements
- R1: While reset is high and in the first cycle after it, `ch_tx_o` is 8'hFF and `tx_underrun_o`, `rx_push_o`, `rx_overflow_o` and `cfg_err_o` are all zero.
- R2: The field of lane l has count `lane_cnt_m1_i[l]`+1 and starts at `lane_start_i[l]`. The lane's next stream bits are placed there in order, the first bit at the start position and later bits toward the MSB. `ch_tx_o` takes the new byte in the cycle after the frame strobe and holds it until the cycle after the next strobe.
- R3: Every bit of `ch_tx_o` not covered by an enabled lane's field equals the same bit of `idle_mask_i` at the strobe.
- R4: The transmit stream of a lane is its FIFO bytes taken LSB first, continuing across frames. `tx_take_o[l]` is high during a strobe cycle exactly when the lane needs a new byte for that frame's field, including part-way through the field. `tx_data_i[l]` is then the byte consumed.
- R5: Several enabled lanes with disjoint fields are merged into the same outgoing byte in one frame.
- R6: If a lane needs a byte and `tx_avail_i[l]` is low at the strobe, its field is sent as all ones and no byte is taken. Its unused partial bits are discarded, and `tx_underrun_o[l]` is high from the cycle after that strobe until the cycle after the next one.
- R7: Each enabled lane appends the bits of its field of `ch_rx_i` to a byte, filling from the LSB. When 8 bits are complete and `rx_space_i[l]` is high at the strobe, `rx_data_o[l]` shows the byte and `rx_push_o[l]` pulses for one cycle after that strobe. Leftover field bits begin the next byte.
- R8: If a byte completes while `rx_space_i[l]` is low, no push occurs and the byte is lost. `rx_overflow_o[l]` is high from the cycle after that strobe until the cycle after the next one.
- R9: `cfg_err_o` is high one cycle after a configuration in which two enabled lanes share any channel bit, or an enabled lane has start plus count greater than 8. It is low otherwise.
- R10: A disabled lane takes no byte, pushes no byte and leaves its positions to the idle mask. Disabling a lane clears its partial transmit and receive state, so on re-enable it fetches a fresh byte and starts a new receive byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | Single-cycle frame strobe |
| lane_en_i | input | N_LANES | Per-lane enable |
| lane_start_i | input | 3*N_LANES | Per-lane field start bit |
| lane_cnt_m1_i | input | 3*N_LANES | Per-lane field bit count minus one |
| idle_mask_i | input | 8 | Value for channel bits no lane drives |
| tx_data_i | input | 8*N_LANES | Head byte of each transmit FIFO |
| tx_avail_i | input | N_LANES | Transmit FIFO has a byte |
| tx_take_o | output | N_LANES | Consume the head byte (strobe cycle) |
| tx_underrun_o | output | N_LANES | Transmit underrun in the last frame |
| ch_tx_o | output | 8 | Outgoing channel byte |
| ch_rx_i | input | 8 | Incoming channel byte, sampled at the strobe |
| rx_data_o | output | 8*N_LANES | Completed receive byte per lane |
| rx_push_o | output | N_LANES | Write `rx_data_o` into the receive FIFO |
| rx_space_i | input | N_LANES | Receive FIFO can accept a byte |
| rx_overflow_o | output | N_LANES | Receive byte dropped in the last frame |
| cfg_err_o | output | 1 | Overlapping or out-of-range field configuration |

## Verification
The assertions check these rules on every cycle:
- the outgoing byte changes only after a strobe;
- no FIFO byte is taken while the FIFO is empty;
- an underrun frame takes no byte;
- a receive push follows only a strobe with space on an enabled lane;
- push and overflow never coincide.

Only the bench's scenarios can show that bits land in the right positions in the right order. They also show where a field fetches mid-way across a byte boundary and that packed receive bytes come out in the 3:2:1 rate ratio. The remaining scenario-only behaviours are the all-ones underrun field, the lost overflow byte, the error detection and the state clearing on disable.

// File: rtl/subch_pkg.sv
package subch_pkg;
  localparam int SLOT_W = 8;
  localparam int POS_W  = $clog2(SLOT_W);
  localparam int CNT_W  = $clog2(SLOT_W);
  localparam int WIN_W  = 2 * SLOT_W;

  // field mask in a double-width window so that spill past the MSB stays visible
  function automatic logic [WIN_W-1:0] span_mask(input logic [POS_W-1:0] start,
                                                 input logic [CNT_W-1:0] cm1);
    return ((WIN_W'(2) << cm1) - WIN_W'(1)) << start;
  endfunction
endpackage

// File: rtl/subch_tx_lane.sv
module subch_tx_lane
  import subch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame,
  input  logic              en,
  input  logic [POS_W-1:0]  start,
  input  logic [CNT_W-1:0]  cm1,
  input  logic [SLOT_W-1:0] head,
  input  logic              head_ok,
  output logic              take,
  output logic [SLOT_W-1:0] fmask,
  output logic [SLOT_W-1:0] fval,
  output logic              underrun
);
  localparam logic [CNT_W:0] FULL = (CNT_W+1)'(SLOT_W);

  logic [SLOT_W-1:0] cur;
  logic [CNT_W:0]    ptr;
  logic              have;
  logic [CNT_W:0]    cnt, avail, rest;
  logic [WIN_W-1:0]  win, sp;
  logic              need, starve;

  always_comb begin
    cnt    = {1'b0, cm1} + 1'b1;
    avail  = have ? (FULL - ptr) : '0;
    need   = cnt > avail;
    rest   = cnt - avail;
    starve = need && !head_ok;
    win    = have ? ({head, cur} >> ptr) : {{SLOT_W{1'b0}}, head};
    sp     = span_mask(start, cm1);
    fmask  = en ? sp[SLOT_W-1:0] : '0;
    fval   = starve ? {SLOT_W{1'b1}} : (win[SLOT_W-1:0] << start);
    take   = frame && en && need && head_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0; ptr <= '0; have <= 1'b0; underrun <= 1'b0;
    end else begin
      if (frame) underrun <= en && starve;
      if (!en) begin
        cur <= '0; ptr <= '0; have <= 1'b0;
      end else if (frame) begin
        if (starve) begin
          ptr <= '0; have <= 1'b0;
        end else if (need) begin
          cur  <= head;
          ptr  <= rest;
          have <= rest != FULL;
        end else begin
          ptr  <= ptr + cnt;
          have <= (ptr + cnt) != FULL;
        end
      end
    end
  end

  // R4
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> head_ok);
  // R6
  underrun_nopop_chk: assert property (@(posedge clk) disable iff (rst)
    (underrun && $past(frame)) |-> !$past(take));
endmodule

// File: rtl/subch_rx_lane.sv
module subch_rx_lane
  import subch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame,
  input  logic              en,
  input  logic [POS_W-1:0]  start,
  input  logic [CNT_W-1:0]  cm1,
  input  logic [SLOT_W-1:0] ch,
  input  logic              space,
  output logic [SLOT_W-1:0] byte_o,
  output logic              push,
  output logic              ovf
);
  logic [SLOT_W-1:0] acc;
  logic [CNT_W:0]    fill, cnt, nfill;
  logic [WIN_W-1:0]  fld, merged;
  logic              full;

  always_comb begin
    cnt    = {1'b0, cm1} + 1'b1;
    fld    = {{SLOT_W{1'b0}}, (ch >> start)} & ((WIN_W'(2) << cm1) - WIN_W'(1));
    merged = {{SLOT_W{1'b0}}, acc} | (fld << fill);
    nfill  = fill + cnt;
    full   = nfill[CNT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0; fill <= '0; byte_o <= '0; push <= 1'b0; ovf <= 1'b0;
    end else begin
      push <= 1'b0;
      if (frame) ovf <= en && full && !space;
      if (!en) begin
        acc <= '0; fill <= '0;
      end else if (frame) begin
        if (full) begin
          if (space) byte_o <= merged[SLOT_W-1:0];
          push <= space;
          acc  <= merged[WIN_W-1:SLOT_W];
          fill <= nfill - (CNT_W+1)'(SLOT_W);
        end else begin
          acc  <= merged[SLOT_W-1:0];
          fill <= nfill;
        end
      end
    end
  end

  // R7
  rx_push_ready_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> $past(space && frame && en));
  // R8
  push_ovf_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(push && ovf));
endmodule

// File: rtl/subch_cfg_chk.sv
module subch_cfg_chk
  import subch_pkg::*;
#(
  parameter int N_LANES = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_LANES-1:0]       en,
  input  logic [N_LANES*POS_W-1:0] start,
  input  logic [N_LANES*CNT_W-1:0] cm1,
  output logic                     err
);
  logic [N_LANES-1:0][WIN_W-1:0] sp;
  logic bad;

  always_comb begin
    bad = 1'b0;
    for (int i = 0; i < N_LANES; i++)
      sp[i] = span_mask(start[i*POS_W +: POS_W], cm1[i*CNT_W +: CNT_W]);
    for (int i = 0; i < N_LANES; i++) begin
      if (en[i] && (|sp[i][WIN_W-1:SLOT_W])) bad = 1'b1;
      for (int j = i + 1; j < N_LANES; j++)
        if (en[i] && en[j] && (|(sp[i] & sp[j]))) bad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= bad;
  end
endmodule

// File: rtl/subch_mux.sv
module subch_mux
  import subch_pkg::*;
#(
  parameter int N_LANES = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      frame_i,
  input  logic [N_LANES-1:0]        lane_en_i,
  input  logic [N_LANES*POS_W-1:0]  lane_start_i,
  input  logic [N_LANES*CNT_W-1:0]  lane_cnt_m1_i,
  input  logic [SLOT_W-1:0]         idle_mask_i,
  input  logic [N_LANES*SLOT_W-1:0] tx_data_i,
  input  logic [N_LANES-1:0]        tx_avail_i,
  output logic [N_LANES-1:0]        tx_take_o,
  output logic [N_LANES-1:0]        tx_underrun_o,
  output logic [SLOT_W-1:0]         ch_tx_o,
  input  logic [SLOT_W-1:0]         ch_rx_i,
  output logic [N_LANES*SLOT_W-1:0] rx_data_o,
  output logic [N_LANES-1:0]        rx_push_o,
  input  logic [N_LANES-1:0]        rx_space_i,
  output logic [N_LANES-1:0]        rx_overflow_o,
  output logic                      cfg_err_o
);
  logic [N_LANES*SLOT_W-1:0] fm_all, fv_all;
  logic [SLOT_W-1:0]         nxt;

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    subch_tx_lane u_tx (
      .clk(clk), .rst(rst), .frame(frame_i), .en(lane_en_i[l]),
      .start(lane_start_i[l*POS_W +: POS_W]), .cm1(lane_cnt_m1_i[l*CNT_W +: CNT_W]),
      .head(tx_data_i[l*SLOT_W +: SLOT_W]), .head_ok(tx_avail_i[l]),
      .take(tx_take_o[l]), .fmask(fm_all[l*SLOT_W +: SLOT_W]),
      .fval(fv_all[l*SLOT_W +: SLOT_W]), .underrun(tx_underrun_o[l]));
    subch_rx_lane u_rx (
      .clk(clk), .rst(rst), .frame(frame_i), .en(lane_en_i[l]),
      .start(lane_start_i[l*POS_W +: POS_W]), .cm1(lane_cnt_m1_i[l*CNT_W +: CNT_W]),
      .ch(ch_rx_i), .space(rx_space_i[l]),
      .byte_o(rx_data_o[l*SLOT_W +: SLOT_W]), .push(rx_push_o[l]),
      .ovf(rx_overflow_o[l]));
  end

  subch_cfg_chk #(.N_LANES(N_LANES)) u_cfg (
    .clk(clk), .rst(rst), .en(lane_en_i), .start(lane_start_i),
    .cm1(lane_cnt_m1_i), .err(cfg_err_o));

  always_comb begin
    nxt = idle_mask_i;
    for (int l = 0; l < N_LANES; l++)
      nxt = (nxt & ~fm_all[l*SLOT_W +: SLOT_W]) |
            (fv_all[l*SLOT_W +: SLOT_W] & fm_all[l*SLOT_W +: SLOT_W]);
  end

  always_ff @(posedge clk) begin
    if (rst)          ch_tx_o <= {SLOT_W{1'b1}};
    else if (frame_i) ch_tx_o <= nxt;
  end

  // R2
  ch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_i) |-> $stable(ch_tx_o));
endmodule

// File: tb/test_subch_mux.sv
`timescale 1ns/1ps
module test_subch_mux;
  localparam int N = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, frame_i, cfg_err_o;
  logic [N-1:0] lane_en_i, tx_avail_i, tx_take_o, tx_underrun_o, rx_push_o, rx_space_i, rx_overflow_o;
  logic [N*3-1:0] lane_start_i, lane_cnt_m1_i;
  logic [7:0] idle_mask_i, ch_tx_o, ch_rx_i;
  logic [N*8-1:0] tx_data_i, rx_data_o;

  subch_mux #(.N_LANES(N)) i_subch_mux (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] drvq [N][$];
  logic [7:0] mq   [N][$];
  logic [7:0] exp_ch [$];
  logic [10:0] exp_rx [$];
  logic cen [N];
  logic [2:0] cst [N], ccm [N];
  int mleft [N], mfill [N];
  logic [7:0] mcur [N], macc [N];
  logic fr_d = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic refresh_tx();
    for (int l = 0; l < N; l++) begin
      tx_avail_i[l] = drvq[l].size() > 0;
      tx_data_i[l*8 +: 8] = (drvq[l].size() > 0) ? drvq[l][0] : 8'h00;
    end
  endtask

  task automatic load(input int l, input logic [7:0] b);
    drvq[l].push_back(b); mq[l].push_back(b); refresh_tx();
  endtask

  task automatic apply_cfg();
    for (int l = 0; l < N; l++) begin
      lane_en_i[l] = cen[l];
      lane_start_i[l*3 +: 3] = cst[l];
      lane_cnt_m1_i[l*3 +: 3] = ccm[l];
      if (!cen[l]) begin mleft[l] = 0; mfill[l] = 0; macc[l] = 8'h00; end
    end
  endtask

  task automatic run_frame(input logic [7:0] rxb, input logic [N-1:0] space);
    logic [7:0] ch;
    logic [N-1:0] epop, eur, eovf, seen;
    int cnt, pos;
    ch = idle_mask_i;
    for (int l = 0; l < N; l++) begin
      epop[l] = 0; eur[l] = 0; eovf[l] = 0;
      if (!cen[l]) begin mleft[l] = 0; mfill[l] = 0; macc[l] = 8'h00; continue; end
      cnt = int'(ccm[l]) + 1;
      if (mleft[l] < cnt && mq[l].size() == 0) begin
        eur[l] = 1; mleft[l] = 0;
        for (int k = 0; k < cnt; k++) begin pos = int'(cst[l]) + k; if (pos < 8) ch[pos] = 1'b1; end
      end else begin
        for (int k = 0; k < cnt; k++) begin
          if (mleft[l] == 0) begin mcur[l] = mq[l].pop_front(); epop[l] = 1; mleft[l] = 8; end
          pos = int'(cst[l]) + k;
          if (pos < 8) ch[pos] = mcur[l][8 - mleft[l]];
          mleft[l]--;
        end
      end
      for (int k = 0; k < cnt; k++) begin
        pos = int'(cst[l]) + k;
        macc[l][mfill[l]] = (pos < 8) ? rxb[pos] : 1'b0;
        mfill[l]++;
        if (mfill[l] == 8) begin
          if (space[l]) exp_rx.push_back({l[2:0], macc[l]});
          else eovf[l] = 1;
          mfill[l] = 0; macc[l] = 8'h00;
        end
      end
    end
    exp_ch.push_back(ch);
    @(negedge clk);
    frame_i = 1'b1; ch_rx_i = rxb; rx_space_i = space;
    #1;
    seen = tx_take_o;
    check(seen == epop, "R4 R10 fifo take", 32'(seen), 32'(epop));
    @(negedge clk);
    frame_i = 1'b0;
    for (int l = 0; l < N; l++) if (seen[l]) void'(drvq[l].pop_front());
    refresh_tx();
    check(tx_underrun_o == eur, "R6 underrun flag", 32'(tx_underrun_o), 32'(eur));
    check(rx_overflow_o == eovf, "R8 overflow flag", 32'(rx_overflow_o), 32'(eovf));
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) fr_d <= frame_i;

  // scoreboard monitor: outgoing bytes and receive pushes
  always @(negedge clk) begin
    logic [7:0] e;
    logic [10:0] r;
    if (!rst && fr_d) begin
      if (exp_ch.size() == 0) check(0, "R2 R3 R5 unexpected channel update", 32'(ch_tx_o), 0);
      else begin
        e = exp_ch.pop_front();
        check(ch_tx_o == e, "R2 R3 R5 channel byte", 32'(ch_tx_o), 32'(e));
      end
    end
    for (int l = 0; l < N; l++) if (!rst && rx_push_o[l]) begin
      if (exp_rx.size() == 0) check(0, "R7 R10 unexpected push", 32'(l), 0);
      else begin
        r = exp_rx.pop_front();
        check({l[2:0], rx_data_o[l*8 +: 8]} == r, "R7 receive byte",
              32'({l[2:0], rx_data_o[l*8 +: 8]}), 32'(r));
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    check(0, "watchdog expired", 0, 0);
    summary();
  end

  initial begin
    rst = 1; frame_i = 0; ch_rx_i = 0; rx_space_i = '1; idle_mask_i = 8'h00;
    lane_en_i = '0; lane_start_i = '0; lane_cnt_m1_i = '0;
    for (int l = 0; l < N; l++) begin cen[l] = 0; cst[l] = 0; ccm[l] = 0; end
    apply_cfg(); refresh_tx();
    repeat (4) @(negedge clk);
    check(ch_tx_o == 8'hFF, "R1 channel reset", 32'(ch_tx_o), 32'hFF);
    rst = 0;
    @(negedge clk);
    check({tx_underrun_o, rx_push_o, rx_overflow_o, cfg_err_o} == '0, "R1 flags reset",
          32'({tx_underrun_o, rx_push_o, rx_overflow_o, cfg_err_o}), 0);
    check(ch_tx_o == 8'hFF, "R1 channel after reset", 32'(ch_tx_o), 32'hFF);

    // single lane, 3 bits at position 2, mask fills the rest (R2 R3 R4)
    idle_mask_i = 8'hA5;
    cen[0] = 1; cst[0] = 3'd2; ccm[0] = 3'd2; apply_cfg();
    load(0, 8'hC6); load(0, 8'h3B); load(0, 8'h91);
    run_frame(8'h1C, '1);
    check(ch_tx_o == 8'hB9, "R2 R3 first field hand value", 32'(ch_tx_o), 32'hB9);
    for (int f = 0; f < 5; f++) run_frame(8'h37 ^ 8'(f * 29), '1);

    // three lanes 3/2/1 bits, two idle positions, dry transmit FIFO, full receive FIFO (R5 R6 R7 R8)
    cen[1] = 1; cst[1] = 3'd3; ccm[1] = 3'd1;
    cen[2] = 1; cst[2] = 3'd7; ccm[2] = 3'd0;
    cst[0] = 3'd0; apply_cfg();
    idle_mask_i = 8'h5A;
    @(negedge clk);
    check(cfg_err_o == 1'b0, "R9 disjoint fields ok", 32'(cfg_err_o), 0);
    for (int b = 0; b < 4; b++) begin load(0, 8'h2D + 8'(b * 71)); load(1, 8'hE4 ^ 8'(b * 13)); end
    load(2, 8'h96); load(2, 8'h0F);
    for (int f = 0; f < 16; f++)
      run_frame(8'h5A ^ 8'(f * 37), (f >= 10) ? 3'b110 : 3'b111);

    // disable lane 1 mid-byte, then re-enable with a fresh byte (R10)
    load(1, 8'hA3); load(1, 8'h6E);
    run_frame(8'hC3, '1);
    cen[1] = 0; apply_cfg();
    run_frame(8'hFF, '1);
    check(ch_tx_o[4:3] == idle_mask_i[4:3], "R10 disabled lane positions from mask",
          32'(ch_tx_o[4:3]), 32'(idle_mask_i[4:3]));
    cen[1] = 1; apply_cfg();
    for (int f = 0; f < 6; f++) run_frame(8'h81 + 8'(f * 17), '1);

    // configuration errors (R9)
    for (int l = 0; l < N; l++) cen[l] = 0;
    cen[0] = 1; cst[0] = 3'd0; ccm[0] = 3'd2;
    cen[1] = 1; cst[1] = 3'd2; ccm[1] = 3'd1; apply_cfg();
    @(negedge clk); @(negedge clk);
    check(cfg_err_o == 1'b1, "R9 overlap flagged", 32'(cfg_err_o), 1);
    cen[1] = 0; apply_cfg();
    @(negedge clk); @(negedge clk);
    check(cfg_err_o == 1'b0, "R9 overlap cleared by disable", 32'(cfg_err_o), 0);
    cst[0] = 3'd6; apply_cfg();
    @(negedge clk); @(negedge clk);
    check(cfg_err_o == 1'b1, "R9 field past MSB flagged", 32'(cfg_err_o), 1);
    cst[0] = 3'd5; apply_cfg();
    @(negedge clk); @(negedge clk);
    check(cfg_err_o == 1'b0, "R9 field ending at MSB ok", 32'(cfg_err_o), 0);

    repeat (3) @(negedge clk);
    check(exp_ch.size() == 0, "R2 pending channel bytes", 32'(exp_ch.size()), 0);
    check(exp_rx.size() == 0, "R7 pending receive bytes", 32'(exp_rx.size()), 0);
    summary();
  end
endmodule